// File: doc/BRIEF.md
# Memory-Fill DMA Channel

This block is one DMA channel that fills a memory region with a repeated 64-bit value. Software programs it through a small register file: a configuration word holding two burst-limit codes and a read-only view of the operation mode, a separate mode register, a destination pointer, a byte count, and a 64-bit fill value split into two 32-bit halves. A command register accepts start, stop, pause and restart bits. It also reports the channel status, a sticky completion flag and a sticky illegal-command flag.

Once started, the channel drives a write-request master port. It issues one 64-bit beat per accepted handshake and walks the address upward in 8-byte steps until the programmed byte count is covered. Beats are grouped into bursts no longer than the destination burst limit. The last burst of a block is shortened to fit. Each command is honoured only in certain states. Every other pairing is dropped and raises the error flag, so the channel behaves as a small command-driven state machine rather than a one-shot fill engine.

Top module: `memfill_dma`

## Requirements
- R1: After reset the status is idle (code 0), done and error are 0, wr_valid is 0, the mode field is 0, and both burst-limit codes are 4.
- R2: Register addresses are: 0 configuration, 1 mode, 2 destination pointer, 3 byte count, 4 fill value low half, 5 fill value high half, 6 command/status. Configuration bits [2:0] hold the destination burst code and bits [6:4] hold the source burst code. Bits [10:8] read back the mode. A configuration write never changes the mode. Only a write to address 1 (bits [2:0]) changes it.
- R3: Command bits at address 6 are bit 0 start, bit 1 stop, bit 2 pause and bit 3 restart. A start is accepted only from idle or paused, and only when all of these hold: the mode is 4 (fill); the byte count lies between MIN_BYTES and MAX_BYTES and is a non-zero multiple of 8; the pointer is 8-byte aligned. It then begins a fresh fill from the destination pointer. Otherwise the start is refused, the status is unchanged and the error flag is set.
- R4: A pause is accepted only while active. The status becomes paused (code 2) and wr_valid drops.
- R5: A restart is accepted only while paused. It makes the channel active again and continues at the first address not yet accepted, with no beat skipped or repeated.
- R6: A stop while active aborts the fill. The status becomes idle and done is not set. A stop while idle is accepted with no effect and no error. A stop while paused is illegal.
- R7: Any other command/state pairing, or a write carrying more than one command bit, is ignored and sets the sticky error flag (status bit 9). Writing 1 to bit 9 clears the flag.
- R8: Each beat carries data {high half, low half}. Addresses run from the pointer upward in steps of 8, for byte count / 8 beats in total.
- R9: Bursts carry wr_first on their first beat and wr_last on their last. Each burst holds the lesser of the burst limit and the beats remaining. Code 0 means 1 beat, and any other code c means c beats. After a pause, the resumed fill opens a new burst.
- R10: When the final beat is accepted, the status is idle from the next cycle and the sticky done flag (status bit 8) is set. Writing 1 to bit 8 clears it. Status bits [5:4] hold 0 for idle, 1 for active and 2 for paused.
- R11: While the channel is active, writes to addresses 0 to 5 are ignored.
- R12: While wr_valid is high and wr_ready is low, the address and data on the master port hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| wr_valid | output | 1 | Write beat request |
| wr_addr | output | 32 | Byte address of the beat |
| wr_data | output | 64 | Fill data of the beat |
| wr_first | output | 1 | First beat of a burst |
| wr_last | output | 1 | Last beat of a burst |
| wr_ready | input | 1 | Beat accepted by the memory side |

## Verification
A register write or command is captured on the rising edge that follows it, and its effect appears on reg_rdata and the master port right after that edge. A start raises wr_valid in the very next cycle. A beat accepted on an edge moves the address and the burst flags on that same edge. The done flag and the idle status appear one cycle after the final beat is accepted. The bench drives every input 2 ns after a rising edge and compares every output against its behavioural model on the falling edge, once all of those registers have settled. Beat and burst totals are counted on the falling edge from the valid/ready pair that the next rising edge will accept.

// File: rtl/memfill_dma.sv
`timescale 1ns/1ps
module memfill_dma #(
  parameter int unsigned MIN_BYTES = 8,
  parameter int unsigned MAX_BYTES = 4096,
  parameter logic [2:0]  FILL_MODE = 3'd4,
  parameter logic [2:0]  BURST_RST = 3'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        wr_valid,
  output logic [31:0] wr_addr,
  output logic [63:0] wr_data,
  output logic        wr_first,
  output logic        wr_last,
  input  logic        wr_ready
);
  localparam logic [1:0]  S_IDLE = 2'd0;
  localparam logic [1:0]  S_ACT  = 2'd1;
  localparam logic [1:0]  S_PAU  = 2'd2;
  localparam logic [31:0] MINB   = 32'(MIN_BYTES);
  localparam logic [31:0] MAXB   = 32'(MAX_BYTES);

  logic [1:0]  st;
  logic [2:0]  mode_q, dburst_q, sburst_q, bcnt, blen;
  logic [31:0] dst_q, size_q, lo_q, hi_q, cur_addr;
  logic [28:0] rem;
  logic        done_q, err_q;

  assign blen     = (dburst_q == 3'd0) ? 3'd1 : dburst_q;
  assign wr_valid = (st == S_ACT);
  assign wr_addr  = cur_addr;
  assign wr_data  = {hi_q, lo_q};
  assign wr_first = (bcnt == 3'd0);
  assign wr_last  = (bcnt == blen - 3'd1) || (rem == 29'd1);

  logic beat, fin, act_wr, start_ok;
  logic c_start, c_stop, c_pause, c_rst, legal, ill;
  logic do_start, do_stop, do_pause, do_rst;

  assign beat   = wr_valid && wr_ready;
  assign fin    = beat && (rem == 29'd1);
  assign act_wr = reg_wr && (reg_addr == 3'd6);

  assign start_ok = (size_q != 32'd0) && (size_q >= MINB) && (size_q <= MAXB) &&
                    (size_q[2:0] == 3'd0) && (dst_q[2:0] == 3'd0) && (mode_q == FILL_MODE);

  assign c_start = act_wr && (reg_wdata[3:0] == 4'b0001);
  assign c_stop  = act_wr && (reg_wdata[3:0] == 4'b0010);
  assign c_pause = act_wr && (reg_wdata[3:0] == 4'b0100);
  assign c_rst   = act_wr && (reg_wdata[3:0] == 4'b1000);

  assign do_start = c_start && (st != S_ACT) && start_ok;
  assign do_stop  = c_stop && (st == S_ACT);
  assign do_pause = c_pause && (st == S_ACT);
  assign do_rst   = c_rst && (st == S_PAU);

  assign legal = do_start || do_stop || do_pause || do_rst || (c_stop && st == S_IDLE);
  assign ill   = act_wr && (reg_wdata[3:0] != 4'd0) && !legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_addr <= '0;
      rem      <= '0;
      bcnt     <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (beat) begin
        cur_addr <= cur_addr + 32'd8;
        rem      <= rem - 29'd1;
        bcnt     <= wr_last ? 3'd0 : bcnt + 3'd1;
      end
      if (fin) begin
        st <= S_IDLE;
      end else if (do_start) begin
        st       <= S_ACT;
        cur_addr <= dst_q;
        rem      <= size_q[31:3];
        bcnt     <= 3'd0;
      end else if (do_stop) begin
        st <= S_IDLE;
      end else if (do_pause) begin
        st   <= S_PAU;
        bcnt <= 3'd0;
      end else if (do_rst) begin
        st <= S_ACT;
      end
      if (fin)                        done_q <= 1'b1;
      else if (act_wr && reg_wdata[8]) done_q <= 1'b0;
      if (ill)                        err_q <= 1'b1;
      else if (act_wr && reg_wdata[9]) err_q <= 1'b0;
    end
  end

  logic cfg_we;
  assign cfg_we = reg_wr && (st != S_ACT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 3'd0;
      dburst_q <= BURST_RST;
      sburst_q <= BURST_RST;
      dst_q    <= '0;
      size_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else if (cfg_we) begin
      case (reg_addr)
        3'd0: begin
          dburst_q <= reg_wdata[2:0];
          sburst_q <= reg_wdata[6:4];
        end
        3'd1: mode_q <= reg_wdata[2:0];
        3'd2: dst_q  <= reg_wdata;
        3'd3: size_q <= reg_wdata;
        3'd4: lo_q   <= reg_wdata;
        3'd5: hi_q   <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {21'd0, mode_q, 1'b0, sburst_q, 1'b0, dburst_q};
      3'd1:    reg_rdata = {29'd0, mode_q};
      3'd2:    reg_rdata = dst_q;
      3'd3:    reg_rdata = size_q;
      3'd4:    reg_rdata = lo_q;
      3'd5:    reg_rdata = hi_q;
      3'd6:    reg_rdata = {22'd0, err_q, done_q, 2'b00, st, 4'b0000};
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

module memfill_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  st,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        wr_last,
  input logic [31:0] wr_addr,
  input logic [63:0] wr_data,
  input logic        done_q,
  input logic [2:0]  dburst_q,
  input logic [2:0]  mode_q,
  input logic [31:0] dst_q,
  input logic [31:0] size_q,
  input logic        reg_wr,
  input logic [2:0]  reg_addr
);
  localparam logic [1:0] S_ACT = 2'd1;
  localparam logic [1:0] S_PAU = 2'd2;

  logic [3:0] nb;
  logic [3:0] lim;
  assign lim = (dburst_q == 3'd0) ? 4'd1 : {1'b0, dburst_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   nb <= 4'd0;
    else if (st != S_ACT)         nb <= 4'd0;
    else if (wr_valid && wr_ready) nb <= wr_last ? 4'd0 : nb + 4'd1;
  end

  AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (nb < lim)); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACT && $past(st == S_ACT && wr_valid && wr_ready)) |-> (wr_addr == $past(wr_addr) + 32'd8)); // R8
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACT && $past(wr_valid && !wr_ready)) |-> ($stable(wr_addr) && $stable(wr_data))); // R12
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(wr_valid && wr_ready && wr_last)); // R10
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACT && $past(st == S_ACT)) |-> ($stable(dst_q) && $stable(size_q))); // R11
  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && reg_addr == 3'd0) |-> $stable(mode_q)); // R2
  AST_PAUSE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAU && $past(st != S_PAU)) |-> ($past(st) == S_ACT)); // R4
endmodule

bind memfill_dma memfill_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_last(wr_last), .wr_addr(wr_addr), .wr_data(wr_data), .done_q(done_q),
  .dburst_q(dburst_q), .mode_q(mode_q), .dst_q(dst_q), .size_q(size_q),
  .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/sim_memfill_dma.sv
`timescale 1ns/1ps
module sim_memfill_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        wr_valid, wr_first, wr_last;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;
  logic        wr_ready = 1'b1;

  integer errors = 0, checks = 0, rdy_pat = 0, nbeats = 0, nburst = 0;
  bit     finished = 1'b0;

  memfill_dma u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_first(wr_first),
    .wr_last(wr_last), .wr_ready(wr_ready)
  );

  always #10 clk = ~clk;

  integer      m_st, m_mode, m_db, m_sb, m_rem, m_left;
  logic [31:0] m_dst, m_size, m_lo, m_hi, m_addr;
  bit          m_done, m_err;

  function automatic integer m_eff();
    integer lim;
    lim = (m_db == 0) ? 1 : m_db;
    if (m_left != 0) return m_left;
    return (lim < m_rem) ? lim : m_rem;
  endfunction

  function automatic bit m_start_ok();
    return (m_size != 0) && (m_size >= 8) && (m_size <= 4096) && (m_size % 8 == 0) &&
           (m_dst % 8 == 0) && (m_mode == 4);
  endfunction

  function automatic logic [31:0] m_rd(input logic [2:0] a);
    case (a)
      3'd0: return 32'(m_mode * 256 + m_sb * 16 + m_db);
      3'd1: return 32'(m_mode);
      3'd2: return m_dst;
      3'd3: return m_size;
      3'd4: return m_lo;
      3'd5: return m_hi;
      3'd6: return 32'(m_err * 512 + m_done * 256 + m_st * 16);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_mode = 0; m_db = 4; m_sb = 4; m_rem = 0; m_left = 0;
      m_dst = 0; m_size = 0; m_lo = 0; m_hi = 0; m_addr = 0; m_done = 0; m_err = 0;
    end else begin
      integer ps, eff, ncmd;
      bit beat, fin, aw, legal;
      ps   = m_st;
      eff  = m_eff();
      beat = (ps == 1) && wr_ready;
      fin  = beat && (m_rem == 1);
      aw   = reg_wr && (reg_addr == 3'd6);
      ncmd = reg_wdata[0] + reg_wdata[1] + reg_wdata[2] + reg_wdata[3];
      legal = 0;
      if (aw && ncmd == 1) begin
        if (reg_wdata[0] && ps != 1 && m_start_ok()) legal = 1;
        if (reg_wdata[1] && ps != 2) legal = 1;
        if (reg_wdata[2] && ps == 1) legal = 1;
        if (reg_wdata[3] && ps == 2) legal = 1;
      end
      if (beat) begin m_addr = m_addr + 8; m_rem = m_rem - 1; m_left = eff - 1; end
      if (fin) begin
        m_st = 0; m_done = 1;
      end else if (legal) begin
        if (reg_wdata[0]) begin m_st = 1; m_addr = m_dst; m_rem = m_size / 8; m_left = 0; end
        else if (reg_wdata[1]) m_st = 0;
        else if (reg_wdata[2]) begin m_st = 2; m_left = 0; end
        else m_st = 1;
      end
      if (!fin && aw && reg_wdata[8]) m_done = 0;
      if (aw && ncmd != 0 && !legal) m_err = 1;
      else if (aw && reg_wdata[9]) m_err = 0;
      if (reg_wr && ps != 1) begin
        case (reg_addr)
          3'd0: begin m_db = reg_wdata[2:0]; m_sb = reg_wdata[6:4]; end
          3'd1: m_mode = reg_wdata[2:0];
          3'd2: m_dst = reg_wdata;
          3'd3: m_size = reg_wdata;
          3'd4: m_lo = reg_wdata;
          3'd5: m_hi = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 R10 wr_valid", {63'd0, wr_valid}, {63'd0, m_st == 1});
      chk("R2 R10 reg_rdata", {32'd0, reg_rdata}, {32'd0, m_rd(reg_addr)});
      if (m_st == 1) begin
        chk("R8 wr_addr", {32'd0, wr_addr}, {32'd0, m_addr});
        chk("R8 wr_data", wr_data, {m_hi, m_lo});
        chk("R9 wr_first", {63'd0, wr_first}, {63'd0, m_left == 0});
        chk("R9 wr_last", {63'd0, wr_last}, {63'd0, m_eff() == 1});
      end
      if (wr_valid && wr_ready) begin
        nbeats++;
        if (wr_first) nburst++;
      end
    end
  end

  initial begin
    integer cyc;
    cyc = 0;
    forever begin
      @(posedge clk); #2;
      cyc++;
      case (rdy_pat)
        1: wr_ready = (cyc % 3 != 0);
        2: wr_ready = 1'b0;
        default: wr_ready = 1'b1;
      endcase
    end
  end

  task automatic step(); @(posedge clk); #2; endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = 32'd0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; #1;
    chk(tag, {32'd0, reg_rdata}, {32'd0, exp});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && m_st != 0; i++) step();
  endtask

  task automatic fill(input logic [31:0] dst, input logic [31:0] size);
    wreg(3'd2, dst); wreg(3'd3, size);
    nbeats = 0; nburst = 0;
    wreg(3'd6, 32'h1);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step();
    // R1
    rd(3'd0, 32'h044, "R1 cfg reset");
    rd(3'd6, 32'h000, "R1 status reset");
    chk("R1 valid reset", {63'd0, wr_valid}, 64'd0);

    // R2
    wreg(3'd1, 32'd4);
    wreg(3'd0, 32'h733);
    rd(3'd0, 32'h433, "R2 cfg write keeps mode");
    wreg(3'd0, 32'h044);
    rd(3'd0, 32'h444, "R2 cfg readback");
    wreg(3'd4, 32'h11223344);
    wreg(3'd5, 32'hAABBCCDD);

    // R8 R10
    fill(32'h100, 32'd64);
    rd(3'd6, 32'h010, "R3 status active");
    wait_idle();
    rd(3'd6, 32'h100, "R10 done set");
    chk("R8 beat total", 64'(nbeats), 64'd8);
    chk("R9 bursts of 4", 64'(nburst), 64'd2);
    wreg(3'd6, 32'h100);
    rd(3'd6, 32'h000, "R10 done cleared");

    // R9 R12 with back-pressure
    wreg(3'd0, 32'h033);
    rdy_pat = 1;
    fill(32'h180, 32'd56);
    wait_idle();
    rdy_pat = 0;
    chk("R12 beat total", 64'(nbeats), 64'd7);
    chk("R9 bursts 3-3-1", 64'(nburst), 64'd3);
    wreg(3'd0, 32'h040);
    fill(32'h1C0, 32'd24);
    wait_idle();
    chk("R9 code0 single bursts", 64'(nburst), 64'd3);
    wreg(3'd0, 32'h044);
    wreg(3'd6, 32'h100);

    // R4 R5 R6 R7 R11
    fill(32'h200, 32'd128);
    step(); step(); step();
    wreg(3'd6, 32'h4);
    rd(3'd6, 32'h020, "R4 paused");
    chk("R4 valid low", {63'd0, wr_valid}, 64'd0);
    wreg(3'd6, 32'h4);
    rd(3'd6, 32'h220, "R7 pause while paused");
    wreg(3'd6, 32'h200);
    wreg(3'd6, 32'h2);
    rd(3'd6, 32'h220, "R6 stop while paused illegal");
    wreg(3'd6, 32'h200);
    wreg(3'd2, 32'h300);
    wreg(3'd6, 32'h8);
    rd(3'd6, 32'h010, "R5 restart active");
    wreg(3'd6, 32'h1);
    rd(3'd6, 32'h210, "R7 start while active");
    wreg(3'd2, 32'h9990000);
    rd(3'd2, 32'h300, "R11 dst frozen");
    wreg(3'd3, 32'd8);
    rd(3'd3, 32'd128, "R11 size frozen");
    wreg(3'd6, 32'h200);
    wait_idle();
    chk("R5 no beat lost or repeated", 64'(nbeats), 64'd16);
    wreg(3'd6, 32'h100);

    // R6 stop
    fill(32'h300, 32'd128);
    step(); step();
    wreg(3'd6, 32'h2);
    rd(3'd6, 32'h000, "R6 stop active no done");
    step(); step();
    chk("R6 stopped valid low", {63'd0, wr_valid}, 64'd0);
    wreg(3'd6, 32'h2);
    rd(3'd6, 32'h000, "R6 stop idle no error");

    // R3 refusals and bounds
    fill(32'h300, 32'd4);
    rd(3'd6, 32'h200, "R3 size below min");
    wreg(3'd6, 32'h200);
    fill(32'h300, 32'd4104);
    rd(3'd6, 32'h200, "R3 size above max");
    wreg(3'd6, 32'h200);
    fill(32'h300, 32'd12);
    rd(3'd6, 32'h200, "R3 size not multiple of 8");
    wreg(3'd6, 32'h200);
    fill(32'h104, 32'd64);
    rd(3'd6, 32'h200, "R3 misaligned pointer");
    wreg(3'd6, 32'h200);
    wreg(3'd1, 32'd3);
    fill(32'h300, 32'd64);
    rd(3'd6, 32'h200, "R3 wrong mode");
    wreg(3'd6, 32'h200);
    wreg(3'd1, 32'd4);
    fill(32'h0, 32'd4096);
    rd(3'd6, 32'h010, "R3 max size accepted");
    wreg(3'd6, 32'h2);
    fill(32'h300, 32'd8);
    wait_idle();
    chk("R3 min size one beat", 64'(nbeats), 64'd1);
    wreg(3'd6, 32'h100);

    // R7 multiple bits
    wreg(3'd6, 32'h3);
    rd(3'd6, 32'h200, "R7 two command bits");
    wreg(3'd6, 32'h200);

    // R3 start from paused
    fill(32'h400, 32'd32);
    step();
    wreg(3'd6, 32'h4);
    wreg(3'd2, 32'h500);
    nbeats = 0;
    wreg(3'd6, 32'h1);
    rd(3'd6, 32'h010, "R3 start from paused");
    wait_idle();
    chk("R3 fresh fill after paused start", 64'(nbeats), 64'd4);
    step();
    finish_run();
  end
endmodule